// File: doc/BRIEF.md
# Pipelined Memory-Programming Command Engine

This block runs the command stream of a non-volatile memory programmer. It reads 40-bit command words from a command FIFO through a first-word-fall-through read port. The FIFO presents its head word whenever it is not empty, and a read strobe pops that word. Each command passes through three stages: fetch, decode and execute. A register bank sits between each pair of stages, so three commands can be in flight at once.

The execute stage does one of the following for each command:
- sends an erase, program or verify request to a memory-operation port that uses a request/acknowledge handshake;
- writes one of a small set of parameter registers;
- completes at once with no action.

While a memory request waits for its acknowledge, execute raises a stall. The stall freezes the fetch and decode registers and blocks FIFO reads. Commands therefore reach the memory strictly in order, so an erase finishes before the program that follows it, and the program finishes before its verify. Every command ends with a one-cycle completion pulse that carries its opcode and a pass flag. A sticky error bit records any failure until it is cleared.

Top module: `prog_cmd_pipe`

## Requirements
- R1: After reset, cmd_rd_o, mem_req_o, stall_o, done_o, done_pass_o and err_o are 0, done_op_o is 0, and every parameter register reads 0.
- R2: cmd_rd_o is high only when cmd_empty_i is low and stall_o is low. Each high cycle pops exactly one word.
- R3: If nothing stalls, a command popped at clock edge k produces done_o after edge k+2. A FIFO that is never empty yields one completion per cycle.
- R4: When the FIFO is empty, fetch inserts a bubble. A bubble produces no completion, no memory request and no second read of an earlier command.
- R5: The command word holds the opcode in bits [39:36], the address in [35:16] and the data in [15:0]. The opcodes are 0 no-op, 1 erase, 2 program, 3 verify and 4 set-parameter.
- R6: Erase, program and verify drive mem_req_o with mem_op_o equal to 0, 1 or 2 respectively, together with the command's address on mem_addr_o and its data on mem_wdata_o. The request and its fields hold steady until the cycle in which mem_ack_i is high. stall_o is high while the request is unacknowledged, and no FIFO read happens during that time.
- R7: Completions leave in command order, and memory requests are issued in command order.
- R8: A verify passes (done_pass_o=1) only if mem_rdata_i equals the command data in the acknowledge cycle. Erase, program, no-op and set-parameter always pass.
- R9: Every completion with done_pass_o=0 sets err_o. err_o stays set until err_clr_i is high while no failure completes. A failure in the same cycle as err_clr_i wins.
- R10: Set-parameter writes the data field to the parameter register selected by address bits [1:0], which appears at param_o[sel*16 +: 16]. It completes in one cycle and never raises mem_req_o.
- R11: Opcodes 5 to 15 complete in one cycle with done_pass_o=0 and done_op_o equal to the raw opcode, and they issue no memory request.
- R12: done_op_o reports the opcode of the completed command, and a no-op completes with done_pass_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_data_i | input | 40 | Head word of the command FIFO |
| cmd_empty_i | input | 1 | Command FIFO empty |
| cmd_rd_o | output | 1 | Pop the head word |
| mem_req_o | output | 1 | Memory operation request |
| mem_op_o | output | 2 | 0 erase, 1 program, 2 verify |
| mem_addr_o | output | 20 | Memory operation address |
| mem_wdata_o | output | 16 | Program data / verify expected data |
| mem_ack_i | input | 1 | Memory operation complete |
| mem_rdata_i | input | 16 | Read-back data, valid with ack |
| stall_o | output | 1 | Pipeline held by outstanding request |
| done_o | output | 1 | One-cycle completion pulse |
| done_op_o | output | 4 | Opcode of completed command |
| done_pass_o | output | 1 | Completed command passed |
| err_o | output | 1 | Sticky failure flag |
| err_clr_i | input | 1 | Clear the sticky failure flag |
| param_o | output | 64 | Parameter registers, 16 bits each |

## Verification
The hardest state to reach is a stall that lasts several cycles while both the fetch and decode registers hold live commands and the FIFO still has words waiting. In that state a frozen register could drop or duplicate a command. The bench preloads long command streams, then sweeps the acknowledge latency from zero to four cycles over erase/program/verify/set-parameter sequences. It checks that completions stay in order and that exactly one command completes per pop. It also checks that a failing verify still sets the error bit while a clear is held high.

// File: rtl/prog_cmd_pkg.sv
package prog_cmd_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP    = 4'd0,
    OP_ERASE  = 4'd1,
    OP_PROG   = 4'd2,
    OP_VERIFY = 4'd3,
    OP_SETP   = 4'd4
  } opcode_e;

  typedef enum logic [1:0] {
    MEM_ERASE  = 2'd0,
    MEM_PROG   = 2'd1,
    MEM_VERIFY = 2'd2
  } mem_op_e;
endpackage

// File: rtl/prog_cmd_fetch.sv
module prog_cmd_fetch #(
  parameter int CMD_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CMD_W-1:0] cmd_data_i,
  input  logic             cmd_empty_i,
  input  logic             stall_i,
  output logic             cmd_rd_o,
  output logic             f_valid_o,
  output logic [CMD_W-1:0] f_word_o
);
  assign cmd_rd_o = !cmd_empty_i && !stall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_valid_o <= 1'b0;
      f_word_o  <= '0;
    end else if (!stall_i) begin
      // empty FIFO: bubble, never a replay of the last word
      f_valid_o <= !cmd_empty_i;
      f_word_o  <= cmd_empty_i ? '0 : cmd_data_i;
    end
  end

  AST_RD_NOT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_rd_o |-> !cmd_empty_i); // R2
  AST_NO_RD_IN_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !cmd_rd_o); // R6
endmodule

// File: rtl/prog_cmd_decode.sv
module prog_cmd_decode
  import prog_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int CMD_W = OP_W + ADDR_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic              f_valid_i,
  input  logic [CMD_W-1:0]  f_word_i,
  output logic              d_valid_o,
  output logic [OP_W-1:0]   d_op_o,
  output logic              d_is_mem_o,
  output logic [1:0]        d_mem_op_o,
  output logic              d_is_param_o,
  output logic              d_illegal_o,
  output logic [ADDR_W-1:0] d_addr_o,
  output logic [DATA_W-1:0] d_data_o
);
  logic [OP_W-1:0] op;
  logic            is_mem, is_param, illegal;
  mem_op_e         mem_op;

  assign op = f_word_i[CMD_W-1 -: OP_W];

  always_comb begin
    is_mem   = 1'b0;
    is_param = 1'b0;
    illegal  = 1'b0;
    mem_op   = MEM_ERASE;
    case (op)
      OP_NOP:    ;
      OP_ERASE:  begin is_mem = 1'b1; mem_op = MEM_ERASE;  end
      OP_PROG:   begin is_mem = 1'b1; mem_op = MEM_PROG;   end
      OP_VERIFY: begin is_mem = 1'b1; mem_op = MEM_VERIFY; end
      OP_SETP:   is_param = 1'b1;
      default:   illegal = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_valid_o    <= 1'b0;
      d_op_o       <= '0;
      d_is_mem_o   <= 1'b0;
      d_mem_op_o   <= '0;
      d_is_param_o <= 1'b0;
      d_illegal_o  <= 1'b0;
      d_addr_o     <= '0;
      d_data_o     <= '0;
    end else if (!stall_i) begin
      d_valid_o    <= f_valid_i;
      d_op_o       <= op;
      d_is_mem_o   <= f_valid_i && is_mem;
      d_mem_op_o   <= mem_op;
      d_is_param_o <= f_valid_i && is_param;
      d_illegal_o  <= f_valid_i && illegal;
      d_addr_o     <= f_word_i[DATA_W +: ADDR_W];
      d_data_o     <= f_word_i[DATA_W-1:0];
    end
  end

  AST_DECODE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(d_valid_o) && $stable(d_addr_o) && $stable(d_data_o)); // R6
endmodule

// File: rtl/prog_cmd_execute.sv
module prog_cmd_execute
  import prog_cmd_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int NUM_PARAM = 4,
  localparam int PSEL_W   = (NUM_PARAM > 1) ? $clog2(NUM_PARAM) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        d_valid_i,
  input  logic [OP_W-1:0]             d_op_i,
  input  logic                        d_is_mem_i,
  input  logic [1:0]                  d_mem_op_i,
  input  logic                        d_is_param_i,
  input  logic                        d_illegal_i,
  input  logic [ADDR_W-1:0]           d_addr_i,
  input  logic [DATA_W-1:0]           d_data_i,
  output logic                        mem_req_o,
  output logic [1:0]                  mem_op_o,
  output logic [ADDR_W-1:0]           mem_addr_o,
  output logic [DATA_W-1:0]           mem_wdata_o,
  input  logic                        mem_ack_i,
  input  logic [DATA_W-1:0]           mem_rdata_i,
  output logic                        stall_o,
  output logic                        done_o,
  output logic [OP_W-1:0]             done_op_o,
  output logic                        done_pass_o,
  output logic                        err_o,
  input  logic                        err_clr_i,
  output logic [NUM_PARAM*DATA_W-1:0] param_o
);
  logic              fire, pass_c, setp_fire;
  logic [PSEL_W-1:0] psel;

  assign mem_req_o   = d_valid_i && d_is_mem_i;
  assign mem_op_o    = d_mem_op_i;
  assign mem_addr_o  = d_addr_i;
  assign mem_wdata_o = d_data_i;
  assign stall_o     = mem_req_o && !mem_ack_i;
  assign fire        = d_valid_i && !stall_o;
  assign setp_fire   = fire && d_is_param_i;
  assign psel        = d_addr_i[PSEL_W-1:0];

  always_comb begin
    if (d_illegal_i)                                      pass_c = 1'b0;
    else if (d_is_mem_i && d_mem_op_i == 2'(MEM_VERIFY))  pass_c = (mem_rdata_i == d_data_i);
    else                                                  pass_c = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      done_op_o   <= '0;
      done_pass_o <= 1'b0;
    end else begin
      done_o <= fire;
      if (fire) begin
        done_op_o   <= d_op_i;
        done_pass_o <= pass_c;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                err_o <= 1'b0;
    else if (fire && !pass_c)   err_o <= 1'b1;  // set beats clear
    else if (err_clr_i)         err_o <= 1'b0;
  end

  for (genvar g = 0; g < NUM_PARAM; g++) begin : g_param
    logic [DATA_W-1:0] param_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 param_q <= '0;
      else if (setp_fire && psel == PSEL_W'(g))    param_q <= d_data_i;
    end
    assign param_o[g*DATA_W +: DATA_W] = param_q;
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_op_o)
                                && $stable(mem_wdata_o)); // R6
  AST_FAIL_SETS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !done_pass_o |-> err_o); // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !err_clr_i |=> err_o); // R9
  AST_NOP_PASSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && done_op_o == OP_NOP |-> done_pass_o); // R12
endmodule

// File: rtl/prog_cmd_pipe.sv
module prog_cmd_pipe
  import prog_cmd_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int NUM_PARAM = 4,
  localparam int CMD_W    = OP_W + ADDR_W + DATA_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [CMD_W-1:0]            cmd_data_i,
  input  logic                        cmd_empty_i,
  output logic                        cmd_rd_o,
  output logic                        mem_req_o,
  output logic [1:0]                  mem_op_o,
  output logic [ADDR_W-1:0]           mem_addr_o,
  output logic [DATA_W-1:0]           mem_wdata_o,
  input  logic                        mem_ack_i,
  input  logic [DATA_W-1:0]           mem_rdata_i,
  output logic                        stall_o,
  output logic                        done_o,
  output logic [OP_W-1:0]             done_op_o,
  output logic                        done_pass_o,
  output logic                        err_o,
  input  logic                        err_clr_i,
  output logic [NUM_PARAM*DATA_W-1:0] param_o
);
  logic              f_valid;
  logic [CMD_W-1:0]  f_word;
  logic              d_valid, d_is_mem, d_is_param, d_illegal;
  logic [OP_W-1:0]   d_op;
  logic [1:0]        d_mem_op;
  logic [ADDR_W-1:0] d_addr;
  logic [DATA_W-1:0] d_data;

  prog_cmd_fetch #(.CMD_W(CMD_W)) i_fetch (
    .clk_i, .rst_ni,
    .cmd_data_i, .cmd_empty_i,
    .stall_i   (stall_o),
    .cmd_rd_o,
    .f_valid_o (f_valid),
    .f_word_o  (f_word)
  );

  prog_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_decode (
    .clk_i, .rst_ni,
    .stall_i      (stall_o),
    .f_valid_i    (f_valid),
    .f_word_i     (f_word),
    .d_valid_o    (d_valid),
    .d_op_o       (d_op),
    .d_is_mem_o   (d_is_mem),
    .d_mem_op_o   (d_mem_op),
    .d_is_param_o (d_is_param),
    .d_illegal_o  (d_illegal),
    .d_addr_o     (d_addr),
    .d_data_o     (d_data)
  );

  prog_cmd_execute #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PARAM(NUM_PARAM)) i_execute (
    .clk_i, .rst_ni,
    .d_valid_i    (d_valid),
    .d_op_i       (d_op),
    .d_is_mem_i   (d_is_mem),
    .d_mem_op_i   (d_mem_op),
    .d_is_param_i (d_is_param),
    .d_illegal_i  (d_illegal),
    .d_addr_i     (d_addr),
    .d_data_i     (d_data),
    .mem_req_o, .mem_op_o, .mem_addr_o, .mem_wdata_o,
    .mem_ack_i, .mem_rdata_i,
    .stall_o, .done_o, .done_op_o, .done_pass_o,
    .err_o, .err_clr_i, .param_o
  );
endmodule

// File: tb/test_prog_cmd_pipe.sv
module test_prog_cmd_pipe;
  localparam int AW = 20, DW = 16, NP = 4, CW = 40, QN = 512;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic [CW-1:0] cmd_data_i;
  logic          cmd_empty_i, cmd_rd_o;
  logic          mem_req_o, mem_ack_i;
  logic [1:0]    mem_op_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o, mem_rdata_i;
  logic          stall_o, done_o, done_pass_o, err_o;
  logic          err_clr_i = 1'b0;
  logic [3:0]    done_op_o;
  logic [NP*DW-1:0] param_o;

  prog_cmd_pipe i_prog_cmd_pipe (.*);

  always #2 clk_i = ~clk_i;

  int n_tests = 0, n_fail = 0, cyc = 0;
  // FIFO model
  logic [CW-1:0] q [QN];
  int head = 0, tail = 0;
  int pop_edge [QN];
  assign cmd_empty_i = (head == tail);
  assign cmd_data_i  = q[head % QN];

  // memory model
  logic [DW-1:0] mem_q [16];
  int lat = 0, wcnt = 0;
  assign mem_ack_i   = mem_req_o && (wcnt >= lat);
  assign mem_rdata_i = mem_q[mem_addr_o[3:0]];

  // reference state
  logic [3:0]    exp_op   [QN];
  logic          exp_pass [QN];
  logic [1:0]    exp_mop  [QN];
  logic [AW-1:0] exp_madr [QN];
  logic [DW-1:0] exp_mdat [QN];
  logic [DW-1:0] ref_mem [16];
  logic [DW-1:0] ref_par [NP];
  int n_exp = 0, exp_idx = 0, n_mem = 0, midx = 0, n_done = 0;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cmd_rd_o) begin
      pop_edge[head % QN] <= cyc + 1;
      head <= head + 1;
    end
    if (mem_req_o && !mem_ack_i) wcnt <= wcnt + 1; else wcnt <= 0;
    if (mem_req_o && mem_ack_i) begin
      if (mem_op_o == 2'd0)      mem_q[mem_addr_o[3:0]] <= 16'hFFFF;
      else if (mem_op_o == 2'd1) mem_q[mem_addr_o[3:0]] <= mem_wdata_o;
    end
    if (cyc > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // monitor, sampled away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (done_o) begin
        n_done++;
        if (exp_idx >= n_exp) chk(1'b0, "R4 extra completion", 64'(exp_idx), 64'(n_exp));
        else begin
          chk(done_op_o == exp_op[exp_idx], "R7 done_op order", 64'(done_op_o), 64'(exp_op[exp_idx]));
          chk(done_pass_o == exp_pass[exp_idx], "R8 pass flag", 64'(done_pass_o), 64'(exp_pass[exp_idx]));
          if (lat == 0)
            chk(cyc == pop_edge[exp_idx] + 2, "R3 latency", 64'(cyc), 64'(pop_edge[exp_idx] + 2));
          exp_idx++;
        end
        if (!done_pass_o) chk(err_o == 1'b1, "R9 fail sets err", 64'(err_o), 64'd1);
      end
      if (stall_o) chk(!cmd_rd_o, "R6 no read in stall", 64'(cmd_rd_o), 64'd0);
      if (mem_req_o && mem_ack_i) begin
        if (midx >= n_mem) chk(1'b0, "R10 unexpected mem req", 64'(midx), 64'(n_mem));
        else begin
          chk(mem_op_o == exp_mop[midx], "R6 mem op", 64'(mem_op_o), 64'(exp_mop[midx]));
          chk(mem_addr_o == exp_madr[midx], "R5 mem addr", 64'(mem_addr_o), 64'(exp_madr[midx]));
          chk(mem_wdata_o == exp_mdat[midx], "R5 mem data", 64'(mem_wdata_o), 64'(exp_mdat[midx]));
          midx++;
        end
      end
    end
  end

  task automatic add_mem(input logic [1:0] o, input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_mop[n_mem] = o; exp_madr[n_mem] = a; exp_mdat[n_mem] = d; n_mem++;
  endtask

  task automatic push(input logic [3:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic p;
    p = 1'b1;
    case (op)
      4'd0: ;
      4'd1: begin ref_mem[a[3:0]] = 16'hFFFF; add_mem(2'd0, a, d); end
      4'd2: begin ref_mem[a[3:0]] = d;        add_mem(2'd1, a, d); end
      4'd3: begin p = (ref_mem[a[3:0]] == d); add_mem(2'd2, a, d); end
      4'd4: ref_par[a[1:0]] = d;
      default: p = 1'b0;  // R11
    endcase
    exp_op[n_exp] = op; exp_pass[n_exp] = p; n_exp++;
    q[tail % QN] = {op, a, d};
    tail++;
  endtask

  task automatic drain();
    while (exp_idx != n_exp || head != tail) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin mem_q[i] = 16'h0; ref_mem[i] = 16'h0; end
    for (int i = 0; i < NP; i++) ref_par[i] = '0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!done_o && !mem_req_o && !stall_o && !cmd_rd_o, "R1 idle outputs", 64'({done_o, mem_req_o, stall_o, cmd_rd_o}), 64'd0);
    chk(!err_o && !done_pass_o && done_op_o == 4'd0, "R1 status", 64'({err_o, done_pass_o, done_op_o}), 64'd0);
    chk(param_o == '0, "R1 params", param_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3 R5 R11 R12: every opcode back to back, zero-wait memory
    lat = 0;
    push(4'd1, 20'h00005, 16'h0);
    push(4'd2, 20'h00005, 16'hA5C3);
    push(4'd3, 20'h00005, 16'hA5C3);
    push(4'd3, 20'h00005, 16'hA5C2);
    for (int op = 0; op < 16; op++)
      for (int k = 0; k < 2; k++)
        push(4'(op), 20'(op * 7 + k * 16'h111 + 20'h10000), 16'(op * 16'h1111 + k));
    drain();
    chk(err_o == 1'b1, "R9 err after failures", 64'(err_o), 64'd1);
    @(negedge clk_i) err_clr_i = 1'b1;
    @(negedge clk_i) err_clr_i = 1'b0;
    chk(err_o == 1'b0, "R9 clear", 64'(err_o), 64'd0);
    repeat (3) @(negedge clk_i);
    chk(err_o == 1'b0, "R9 stays clear", 64'(err_o), 64'd0);

    // R6 R7 R8: ordered sequences under swept ack latency
    for (int l = 1; l <= 4; l++) begin
      lat = l;
      for (int r = 0; r < 3; r++) begin
        push(4'd1, 20'(r + l * 3), 16'h0);
        push(4'd3, 20'(r + l * 3), 16'hFFFF);
        push(4'd2, 20'(r + l * 3), 16'(l * 16'h0101 + r));
        push(4'd4, 20'(r), 16'(l * 16'h10 + r));
        push(4'd3, 20'(r + l * 3), 16'(l * 16'h0101 + r));
        push(4'd3, 20'(r + l * 3), 16'(l * 16'h0101 + r + 1));
        push(4'd0, 20'h0, 16'h0);
      end
      drain();
    end

    // R4 bubbles with growing gaps
    lat = 0;
    for (int g = 0; g < 5; g++) begin
      push(4'd4, 20'(g), 16'(16'hBE00 + g));
      push(4'd2, 20'(g + 8), 16'(16'h5A00 + g));
      repeat (g) @(negedge clk_i);
    end
    drain();
    begin
      int nd;
      nd = n_done;
      repeat (6) @(negedge clk_i);
      chk(n_done == nd, "R4 no completion when idle", 64'(n_done), 64'(nd));
      chk(!cmd_rd_o && !mem_req_o, "R4 idle port", 64'({cmd_rd_o, mem_req_o}), 64'd0);
    end

    // R9 set wins over a held clear
    lat = 2;
    err_clr_i = 1'b1;
    @(negedge clk_i);
    push(4'd3, 20'h00009, 16'h1234);
    push(4'd9, 20'h0, 16'h0);
    push(4'd0, 20'h0, 16'h0);
    drain();
    err_clr_i = 1'b0;
    @(negedge clk_i);

    // R10 parameters and memory request count
    for (int s = 0; s < NP; s++)
      chk(param_o[s*DW +: DW] == ref_par[s], "R10 param value", 64'(param_o[s*DW +: DW]), 64'(ref_par[s]));
    chk(midx == n_mem, "R10 mem request count", 64'(midx), 64'(n_mem));
    chk(exp_idx == n_exp, "R2 one completion per pop", 64'(exp_idx), 64'(n_exp));

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule